// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects interrupt events for a serial bus link controller and presents them to a CPU through a byte-wide register port. Four event sources set sticky bits directly in an 8-bit top status register. Four further sources each own an 8-bit secondary status register with its own enable mask: DMA, PHY, link core group 0 and link core group 1. Each secondary register folds into one summary bit of the top register.

A top enable register selects which top status bits drive the single level-sensitive interrupt line. Software reads the top register to find the source. It acknowledges a direct event bit by writing the read value back, because writing one clears a bit. It acknowledges a summary bit by reading and then clearing the matching secondary register. The summary bit falls by itself once no enabled factor remains in that register.

A synchronous clear input, driven by software reset or bus reset logic, empties every status register and leaves the enable masks as they are. The asynchronous hardware reset clears everything.

Top module: `irq_status_hub`

## Requirements
- R1: The top status register reads at address 0x01. Its bits are: bit 7 self-ID period done, bit 6 self-ID error, bit 5 protocol-engine error, bit 4 bus reset during protocol-engine work. Bits 3, 2, 1 and 0 are the summaries of link group 1, link group 0, PHY and DMA.
- R2: Top bit 6 sets on a self-ID packet error pulse and also on a self-ID abort pulse. Abort means the self-ID period ended because of an error.
- R3: Top bits 7..4 are sticky. A write to 0x01 clears exactly the bits written as one and leaves the others.
- R4: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set. This holds for top and secondary registers.
- R5: Secondary register k has its status at 0x10+2k and its enable at 0x11+2k, with k=0 DMA, 1 PHY, 2 link group 0 and 3 link group 1. Its status bit j sets on `sec_evt_i[8k+j]` and clears when written with one. The enable register reads back the value last written.
- R6: Summary bit k is 1 exactly when some bit is set in both status and enable of secondary k. Writing one to a summary bit at 0x01 does not change it.
- R7: After the pending bits of secondary k are cleared at 0x10+2k, summary bit k reads 0.
- R8: The top enable register is at 0x03. `irq_o` is high one cycle after a cycle in which some top status bit and its top enable bit are both 1, and low otherwise.
- R9: After hardware reset every register reads 0x00 and `irq_o` is 0. A cycle with `stat_clr_i` high makes all status registers read 0x00 afterwards, even against an event pulse in that cycle. The enable registers are kept.
- R10: `rdata_o` is 0x00 when `rd_en_i` is low or when the address is unmapped, for example 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stat_clr_i | input | 1 | Synchronous clear of all status (software or bus reset) |
| ev_sid_done_i | input | 1 | Pulse: self-ID period finished |
| ev_sid_pkt_err_i | input | 1 | Pulse: self-ID packet received with error |
| ev_sid_abort_i | input | 1 | Pulse: self-ID period ended by an error |
| ev_eng_err_i | input | 1 | Pulse: protocol-engine error |
| ev_eng_bus_rst_i | input | 1 | Pulse: bus reset during protocol-engine work |
| sec_evt_i | input | 32 | Secondary event pulses, 8 per source, DMA in the low byte |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Registered active-high interrupt level |

## Verification
The in-module properties check on every cycle four local rules: set-over-clear priority, holding of status and enable bits when nothing touches them, the synchronous clear, and the interrupt level against the previous cycle's masked status. One property also forbids a summary bit from falling unless its secondary register was written or the status was cleared. The whole register picture needs the bench's reference model and its random traffic to show. That picture covers the exact bit layout, the lane-to-register mapping, the read-back of every register after mixed writes, and the rule that a write-back to a summary bit has no effect.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] ADDR_TOP_STAT = 8'h01;
  localparam logic [REG_AW-1:0] ADDR_TOP_EN   = 8'h03;
  localparam logic [REG_AW-1:0] ADDR_SEC_BASE = 8'h10;
  localparam int unsigned N_DIRECT = 4;

  // status of secondary k at base+2k, its enable one above
  function automatic logic [REG_AW-1:0] sec_stat_addr(input int unsigned k);
    return ADDR_SEC_BASE + REG_AW'(2 * k);
  endfunction

  function automatic logic [REG_AW-1:0] sec_en_addr(input int unsigned k);
    return ADDR_SEC_BASE + REG_AW'(2 * k + 1);
  endfunction
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] keep;
  logic             q_en;

  always_comb begin
    keep = clr_we ? ~clr_mask : '1;
    // a pulse landing with a clear keeps the bit
    q_d  = sync_clr ? '0 : ((q_q & keep) | set_i);
    q_en = sync_clr | clr_we | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && (|set_i)) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && !clr_we && (set_i == '0)) |=> $stable(q_o));

  p_sync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (q_o == '0));
endmodule

// File: rtl/irq_sec_channel.sv
module irq_sec_channel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             stat_we,
  input  logic             en_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] stat_o,
  output logic [WIDTH-1:0] en_o,
  output logic             sum_o
);
  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] en_d;

  irq_w1c_bank #(.WIDTH(WIDTH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .set_i    (evt_i),
    .clr_we   (stat_we),
    .clr_mask (wdata),
    .q_o      (stat_o)
  );

  always_comb en_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o  = en_q;
  assign sum_o = |(stat_o & en_q);

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_o));

  p_en_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_o == $past(wdata)));
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_clr_i,
  input  logic             ev_sid_done_i,
  input  logic             ev_sid_pkt_err_i,
  input  logic             ev_sid_abort_i,
  input  logic             ev_eng_err_i,
  input  logic             ev_eng_bus_rst_i,
  input  logic [NS*DW-1:0] sec_evt_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  localparam int unsigned N_EVT = DW - NS;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // write decode
  logic          top_stat_we;
  logic          top_en_we;
  logic [NS-1:0] sec_stat_we;
  logic [NS-1:0] sec_en_we;

  always_comb begin
    top_stat_we = wr_en_i && (addr_i == ADDR_TOP_STAT);
    top_en_we   = wr_en_i && (addr_i == ADDR_TOP_EN);
    for (int k = 0; k < NS; k++) begin
      sec_stat_we[k] = wr_en_i && (addr_i == sec_stat_addr(k));
      sec_en_we[k]   = wr_en_i && (addr_i == sec_en_addr(k));
    end
  end

  // direct event bits, order high to low: done, error, engine error, engine bus reset
  logic [N_EVT-1:0] evt_set;
  logic [N_EVT-1:0] evt_q;
  assign evt_set = N_EVT'({ev_sid_done_i, ev_sid_pkt_err_i | ev_sid_abort_i,
                           ev_eng_err_i, ev_eng_bus_rst_i});

  irq_w1c_bank #(.WIDTH(N_EVT)) u_evt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sync_clr (stat_clr_i),
    .set_i    (evt_set),
    .clr_we   (top_stat_we),
    .clr_mask (wdata_i[DW-1:NS]),
    .q_o      (evt_q)
  );

  // secondary registers
  logic [DW-1:0] sec_stat [NS];
  logic [DW-1:0] sec_en   [NS];
  logic [NS-1:0] sum_w;

  for (genvar k = 0; k < NS; k++) begin : g_sec
    irq_sec_channel #(.WIDTH(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .sync_clr (stat_clr_i),
      .evt_i    (sec_evt_i[k*DW +: DW]),
      .stat_we  (sec_stat_we[k]),
      .en_we    (sec_en_we[k]),
      .wdata    (wdata_i),
      .stat_o   (sec_stat[k]),
      .en_o     (sec_en[k]),
      .sum_o    (sum_w[k])
    );

    p_sum_fall_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
      $fell(sum_w[k]) |-> ($past(sec_stat_we[k]) || $past(sec_en_we[k]) ||
                           $past(stat_clr_i)));
  end

  logic [DW-1:0] top_stat;
  assign top_stat = {evt_q, sum_w};

  // top enable
  logic [DW-1:0] top_en_q;
  logic [DW-1:0] top_en_d;
  always_comb top_en_d = wdata_i;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     top_en_q <= '0;
    else if (top_en_we) top_en_q <= top_en_d;
  end

  // interrupt line
  logic irq_q;
  logic irq_d;
  always_comb irq_d = |(top_stat & top_en_q);
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // read mux
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_TOP_STAT)    rd_mux = top_stat;
    else if (addr_i == ADDR_TOP_EN) rd_mux = top_en_q;
    for (int k = 0; k < NS; k++) begin
      if (addr_i == sec_stat_addr(k)) rd_mux = sec_stat[k];
      if (addr_i == sec_en_addr(k))   rd_mux = sec_en[k];
    end
  end
  assign rdata_o = rd_en_i ? rd_mux : '0;

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (top_en_q == '0) |=> !irq_o);

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(top_stat & top_en_q)) |=> irq_o);

  p_top_clr_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_clr_i |=> (top_stat == '0));
endmodule

// File: tb/irq_status_hub_test.sv
`timescale 1ns/1ps
module irq_status_hub_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stat_clr_i;
  logic        ev_sid_done_i, ev_sid_pkt_err_i, ev_sid_abort_i, ev_eng_err_i, ev_eng_bus_rst_i;
  logic [31:0] sec_evt_i;
  logic [7:0]  addr_i;
  logic        wr_en_i, rd_en_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic        irq_o;

  int n_checks = 0;
  int n_errors = 0;

  // reference model
  logic [3:0] m_evt;
  logic [7:0] m_ten;
  logic [7:0] m_sec [4];
  logic [7:0] m_sen [4];

  always #4 clk = ~clk;

  irq_status_hub uut (
    .clk(clk), .rst_n(rst_n), .stat_clr_i(stat_clr_i),
    .ev_sid_done_i(ev_sid_done_i), .ev_sid_pkt_err_i(ev_sid_pkt_err_i),
    .ev_sid_abort_i(ev_sid_abort_i), .ev_eng_err_i(ev_eng_err_i),
    .ev_eng_bus_rst_i(ev_eng_bus_rst_i), .sec_evt_i(sec_evt_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] m_top();
    logic [3:0] s;
    for (int k = 0; k < 4; k++) s[k] = |(m_sec[k] & m_sen[k]);
    return {m_evt, s};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr_i  = a;
    rd_en_i = 1'b1;
    #1;
    chk(tag, rdata_o, exp);
    rd_en_i = 1'b0;
  endtask

  task automatic check_all(input string tag);
    rd_chk(8'h01, m_top(), {tag, " R1 top status"});
    rd_chk(8'h03, m_ten, {tag, " R8 top enable"});
    for (int k = 0; k < 4; k++) begin
      rd_chk(8'h10 + 8'(2*k), m_sec[k], {tag, " R5 secondary status"});
      rd_chk(8'h11 + 8'(2*k), m_sen[k], {tag, " R5 secondary enable"});
    end
  endtask

  // tev = {done, pkt_err, abort, eng_err, eng_bus_rst}
  task automatic step(input logic [4:0] tev, input logic [31:0] sev, input logic wr,
                      input logic [7:0] a, input logic [7:0] d, input logic sc);
    logic exp_irq;
    logic [3:0] eset;
    @(negedge clk);
    {ev_sid_done_i, ev_sid_pkt_err_i, ev_sid_abort_i, ev_eng_err_i, ev_eng_bus_rst_i} = tev;
    sec_evt_i = sev; wr_en_i = wr; addr_i = a; wdata_i = d; stat_clr_i = sc;
    exp_irq = |(m_top() & m_ten);
    @(posedge clk);
    eset = {tev[4], tev[3] | tev[2], tev[1], tev[0]};
    if (wr && a == 8'h03) m_ten = d;
    for (int k = 0; k < 4; k++) if (wr && a == 8'h11 + 8'(2*k)) m_sen[k] = d;
    if (sc) begin
      m_evt = '0;
      for (int k = 0; k < 4; k++) m_sec[k] = '0;
    end else begin
      if (wr && a == 8'h01) m_evt = m_evt & ~d[7:4];
      m_evt = m_evt | eset;
      for (int k = 0; k < 4; k++) begin
        if (wr && a == 8'h10 + 8'(2*k)) m_sec[k] = m_sec[k] & ~d;
        m_sec[k] = m_sec[k] | sev[8*k +: 8];
      end
    end
    #1;
    {ev_sid_done_i, ev_sid_pkt_err_i, ev_sid_abort_i, ev_eng_err_i, ev_eng_bus_rst_i} = '0;
    sec_evt_i = '0; wr_en_i = 1'b0; stat_clr_i = 1'b0;
    @(negedge clk);
    chk("R8 irq level", {7'd0, irq_o}, {7'd0, exp_irq});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(5'd0, 32'd0, 1'b1, a, d, 1'b0);
  endtask

  task automatic ev(input logic [4:0] tev, input logic [31:0] sev);
    step(tev, sev, 1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    n_errors++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; stat_clr_i = 0; sec_evt_i = 0; addr_i = 0; wr_en_i = 0; rd_en_i = 0; wdata_i = 0;
    {ev_sid_done_i, ev_sid_pkt_err_i, ev_sid_abort_i, ev_eng_err_i, ev_eng_bus_rst_i} = '0;
    m_evt = '0; m_ten = '0;
    for (int k = 0; k < 4; k++) begin m_sec[k] = '0; m_sen[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk("R9 irq after reset", {7'd0, irq_o}, 8'h00);
    check_all("R9 reset");
    // R10: unmapped and unstrobed reads
    rd_chk(8'h02, 8'h00, "R10 unmapped 0x02");

    // R1, R2, R3: direct events
    ev(5'b10000, 0); rd_chk(8'h01, 8'h80, "R1 self-ID done bit7");
    ev(5'b01000, 0); rd_chk(8'h01, 8'hC0, "R2 packet error bit6");
    wr(8'h01, 8'h40); rd_chk(8'h01, 8'h80, "R3 clear only written bit");
    ev(5'b00100, 0); rd_chk(8'h01, 8'hC0, "R2 abort sets bit6");
    ev(5'b00010, 0); rd_chk(8'h01, 8'hE0, "R1 engine error bit5");
    ev(5'b00001, 0); rd_chk(8'h01, 8'hF0, "R1 engine bus reset bit4");
    wr(8'h01, 8'h30); rd_chk(8'h01, 8'hC0, "R3 write-back of subset");
    // R4: collision on the top register
    step(5'b00010, 0, 1'b1, 8'h01, 8'hE0, 1'b0);
    rd_chk(8'h01, 8'h20, "R4 set beats clear top");
    wr(8'h01, 8'hF0); rd_chk(8'h01, 8'h00, "R3 all cleared");

    // R5, R6, R7: secondary path
    ev(5'd0, 32'h0000_0008); rd_chk(8'h10, 8'h08, "R5 DMA status lane 3");
    rd_chk(8'h01, 8'h00, "R6 no summary without enable");
    wr(8'h11, 8'h08); rd_chk(8'h01, 8'h01, "R6 DMA summary bit0");
    wr(8'h01, 8'h0F); rd_chk(8'h01, 8'h01, "R6 top write-one ignored");
    step(5'd0, 32'h0000_0008, 1'b1, 8'h10, 8'h08, 1'b0);
    rd_chk(8'h10, 8'h08, "R4 set beats clear secondary");
    wr(8'h10, 8'h08); rd_chk(8'h01, 8'h00, "R7 summary drops after clear");
    ev(5'd0, 32'h0100_0000); wr(8'h17, 8'hFF);
    rd_chk(8'h16, 8'h01, "R5 link1 status lane 0");
    rd_chk(8'h01, 8'h08, "R1 link1 summary bit3");
    ev(5'd0, 32'h0000_4000); wr(8'h13, 8'h40);
    rd_chk(8'h01, 8'h0A, "R1 PHY summary bit1");

    // R8: interrupt gating and latency
    chk("R8 masked irq", {7'd0, irq_o}, 8'h00);
    wr(8'h03, 8'h08);
    chk("R8 irq not yet", {7'd0, irq_o}, 8'h00);
    ev(5'd0, 0);
    chk("R8 irq after enable", {7'd0, irq_o}, 8'h01);

    // R9: synchronous clear against an event
    step(5'b10000, 32'h0001_0001, 1'b0, 8'h00, 8'h00, 1'b1);
    rd_chk(8'h01, 8'h00, "R9 sync clear top");
    rd_chk(8'h16, 8'h00, "R9 sync clear secondary");
    rd_chk(8'h17, 8'hFF, "R9 enable kept");
    rd_chk(8'h03, 8'h08, "R9 top enable kept");
    // R10: strobe low gives zero
    addr_i = 8'h03; rd_en_i = 1'b0; #1;
    chk("R10 read strobe low", rdata_o, 8'h00);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  tev;
      logic [31:0] sev;
      logic        w, sc;
      logic [7:0]  a, d;
      for (int b = 0; b < 5; b++) tev[b] = ($urandom % 8) == 0;
      for (int b = 0; b < 32; b++) sev[b] = ($urandom % 24) == 0;
      w  = ($urandom % 3) == 0;
      sc = ($urandom % 300) == 0;
      case ($urandom % 10)
        0, 1:    a = 8'h01;
        2:       a = 8'h03;
        default: a = 8'h10 + 8'($urandom % 8);
      endcase
      d = $urandom;
      if (a == 8'h01 && ($urandom % 2)) d = m_top();
      if (a == 8'h03 || a[0]) if (($urandom % 4) != 0) d = d | 8'h0F;
      step(tev, sev, w, a, d, sc);
      check_all("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule